// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequence Detector

This block lives inside a behavioural model of a battery-free nonvolatile SRAM. It watches the memory's bus, which is address, chip enable, output enable and write enable, all active low and sampled on the model clock. It looks for a fixed run of six read addresses. The first five addresses are shared by both runs. The sixth address decides the operation: one value asks for a store into the nonvolatile cells, another asks for a recall from them.

When the sixth read begins, the block sends a one-cycle start pulse toward the nonvolatile array model. It then raises a tri-state request for the data pins and pulls the busy pin low for a fixed number of cycles. The first five reads of a run are ordinary reads and return array data. A read only counts when its address was already settled before both strobes were low. A read whose address moves while the strobes are down is thrown away and clears the progress made so far. Writes also clear the progress, and so does an address that does not follow the run. While busy, the block ignores the bus.

Top module: `nv_seq_detector`

## Requirements
- R1: After a clock edge with `rst_n` low: `hsb_n` = 1, `io_hiz` = 0, `store_start` = 0, `recall_start` = 0, and no progress through the run.
- R2: The store run is six clean reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0. The addresses are compared on all ADDR_W bits, with the upper bits zero. A read begins in the first cycle with `ce_n` = 0, `oe_n` = 0 and `we_n` = 1, and its address is latched in that cycle. When the sixth read begins, the next cycle shows `store_start` = 1 for exactly one cycle. In that same cycle `hsb_n` goes to 0 and `io_hiz` goes to 1.
- R3: The recall run uses the same first five addresses, with 0x4C63 as the sixth. It gives a one-cycle `recall_start` with the same timing and busy behaviour as R2.
- R4: The order in which the strobes fall does not matter. A read where `ce_n` falls before `oe_n`, and a read where `oe_n` falls before `ce_n`, both count. Steps one to five advance when the read ends, which is the first cycle in which either strobe is high again.
- R5: A read counts as address-controlled if its address differs from the latched address in any later cycle while both strobes stay low. Such a read does not advance the run and clears all progress.
- R6: A clean read whose address is not the next one expected clears the progress. If that address equals the first address of the run (0x4E38), it counts as step one of a new run.
- R7: Any cycle with `ce_n` = 0 and `we_n` = 0 outside busy clears the progress and cancels the read in flight.
- R8: After the start pulse, `hsb_n` stays 0 and `io_hiz` stays 1 for exactly BUSY_CYCLES cycles, then both return to idle.
- R9: While busy, reads and writes have no effect. A read that is still in progress when busy ends does not count; a new falling strobe is needed.
- R10: Outside busy, `io_hiz` = 0 and `hsb_n` = 1. This holds during ordinary reads, during the first five reads of a run, and during a sixth read that does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Memory address bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hsb_n | output | 1 | Busy pin level: 0 while a store or recall runs |
| io_hiz | output | 1 | 1 requests high impedance on the data pins |
| store_start | output | 1 | One-cycle pulse that starts a nonvolatile store |
| recall_start | output | 1 | One-cycle pulse that starts a recall |

## Verification
The bench drives several address-level cases:
- An address that moves while both strobes are low. A detector that latched on the strobe rising would accept it and fire.
- A stray repeat of the first address. A matcher without the restart rule would miss the run that follows.
- A write in the middle of a run. If writes are not treated as cancelling, the store still fires.

It also drives timing cases around busy:
- Reads issued during busy, and a sixth read whose strobes stay low past the busy window. A design that kept tracking during busy, or that read a held-low strobe as a new access, would start a second operation.
- The busy length itself. An off-by-one in the timer shows up on `hsb_n` and `io_hiz`.

// File: rtl/nvss_pkg.sv
// Package: shared constants for the store/recall sequence detector.
// Holds the six-step address run and the width of the step counter.
package nvss_pkg;

    localparam int RUN_LEN = 6;
    localparam int STEP_W  = 3;

    localparam logic [15:0] STORE_LAST  = 16'h8FC0;
    localparam logic [15:0] RECALL_LAST = 16'h4C63;

    // Address expected at step idx (0..4) of the run shared by store and recall.
    function automatic logic [15:0] prefix_addr(input int idx);
        case (idx)
            0:       prefix_addr = 16'h4E38;
            1:       prefix_addr = 16'hB1C7;
            2:       prefix_addr = 16'h83E0;
            3:       prefix_addr = 16'h7C1F;
            4:       prefix_addr = 16'h703F;
            default: prefix_addr = 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/nvss_access_tracker.sv
// Module: nvss_access_tracker
// Turns the sampled bus into read-start, read-end and write events.
// Assumes the bus is sampled once per clock. A read is a cycle with both
// strobes low and write enable high. The address is latched in the first such
// cycle. If the address changes while the read is open, the read is marked
// dirty (address-controlled). While hold is high, every event is suppressed
// and the open read is dropped.
module nvss_access_tracker #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              acc_start,
    output logic              acc_end_clean,
    output logic              acc_end_dirty,
    output logic              wr_hit,
    output logic [ADDR_W-1:0] lat_addr
);

    logic rd_now;
    logic rd_prev;
    logic in_acc;
    logic taint;
    logic acc_end;

    // Decode the current bus cycle into events.
    always_comb begin
        rd_now        = ~ce_n & ~oe_n & we_n;
        wr_hit        = ~ce_n & ~we_n & ~hold;
        acc_start     = rd_now & ~rd_prev & ~hold;
        acc_end       = in_acc & ~rd_now & ~hold;
        acc_end_clean = acc_end & ~taint & ~wr_hit;
        acc_end_dirty = acc_end & taint & ~wr_hit;
    end

    // Track the open read: its latched address and whether the address moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev  <= 1'b0;
            in_acc   <= 1'b0;
            taint    <= 1'b0;
            lat_addr <= '0;
        end else begin
            rd_prev <= rd_now;
            if (hold || wr_hit) begin
                in_acc <= 1'b0;
                taint  <= 1'b0;
            end else if (acc_start) begin
                in_acc   <= 1'b1;
                taint    <= 1'b0;
                lat_addr <= addr;
            end else if (acc_end) begin
                in_acc <= 1'b0;
            end else if (in_acc && rd_now && (addr != lat_addr)) begin
                taint <= 1'b1;
            end
        end
    end

    // R9: busy drops any read in flight.
    a_r9_hold_drops_read: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !in_acc);

    // R5: an address change during an open read marks it dirty.
    a_r5_moving_addr_taints: assert property (@(posedge clk) disable iff (!rst_n)
        (in_acc && rd_now && !hold && (addr != lat_addr)) |=> taint);

    // R7: a write closes the open read.
    a_r7_write_closes_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> !in_acc);

endmodule

// File: rtl/nvss_seq_matcher.sv
// Module: nvss_seq_matcher
// Counts progress through the six-address run. Steps one to five advance on
// the end of a clean read. The sixth step is decided when the read starts, so
// the same read can be tri-stated. Assumes events come from
// nvss_access_tracker and are already masked while busy.
module nvss_seq_matcher #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              acc_end_clean,
    input  logic              acc_end_dirty,
    input  logic              wr_hit,
    input  logic [ADDR_W-1:0] lat_addr,
    output logic              fire_store,
    output logic              fire_recall
);

    import nvss_pkg::*;

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RUN_LEN - 1);

    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] next_step;
    logic              at_last;
    logic              first_hit;
    logic              want_hit;

    // Decide the sixth step as the read opens.
    always_comb begin
        at_last     = (step == LAST_STEP);
        fire_store  = acc_start & at_last & (start_addr == ADDR_W'(STORE_LAST));
        fire_recall = acc_start & at_last & (start_addr == ADDR_W'(RECALL_LAST));
    end

    // Work out the step that follows a clean read of lat_addr.
    always_comb begin
        first_hit = (lat_addr == ADDR_W'(prefix_addr(0)));
        want_hit  = !at_last && (lat_addr == ADDR_W'(prefix_addr(int'(step))));
        if (want_hit)
            next_step = step + 1'b1;
        else if (first_hit)
            next_step = STEP_W'(1);
        else
            next_step = '0;
    end

    // Step register: cleared by writes, dirty reads and a completed run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= '0;
        else if (wr_hit || acc_end_dirty || fire_store || fire_recall)
            step <= '0;
        else if (acc_end_clean)
            step <= next_step;
    end

    // R6: progress never goes past the last step.
    a_r6_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST_STEP);

    // R7: a write empties the run.
    a_r7_write_empties_run: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (step == 0));

    // R5: a dirty read empties the run.
    a_r5_dirty_empties_run: assert property (@(posedge clk) disable iff (!rst_n)
        acc_end_dirty |=> (step == 0));

    // R6: a stray first address restarts at step one.
    a_r6_restart_on_first: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_end_clean && !wr_hit && first_hit && !want_hit) |=> (step == 1));

endmodule

// File: rtl/nvss_busy_timer.sv
// Module: nvss_busy_timer
// Turns a store or recall trigger into a one-cycle start pulse and a busy
// window of exactly BUSY_CYCLES cycles. Assumes triggers never arrive while
// busy is high, because the tracker is held during busy.
module nvss_busy_timer #(
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_store,
    input  logic go_recall,
    output logic busy,
    output logic store_start,
    output logic recall_start
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Load the window on a trigger, count it down, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            cnt          <= '0;
            store_start  <= 1'b0;
            recall_start <= 1'b0;
        end else begin
            store_start  <= go_store;
            recall_start <= go_recall;
            if (go_store || go_recall) begin
                busy <= 1'b1;
                cnt  <= LOAD;
            end else if (busy) begin
                if (cnt == '0)
                    busy <= 1'b0;
                else
                    cnt <= cnt - 1'b1;
            end
        end
    end

    // R8: the counter never exceeds the programmed window.
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);

    // R8: busy is not released while cycles remain.
    a_r8_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt != '0)) |=> busy);

    // R2 / R3: a start pulse coincides with the first busy cycle.
    a_r2_pulse_opens_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (store_start || recall_start) |-> (busy && !$past(busy)));

    // R9: no new trigger while busy.
    a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(go_store || go_recall));

endmodule

// File: rtl/nv_seq_detector.sv
// Module: nv_seq_detector (top)
// Detects the six-read store/recall run on the bus of a nonvolatile SRAM model.
// It pulses a start toward the array model, then holds the busy pin low and the
// data pins tri-stated for BUSY_CYCLES cycles. Assumes the bus is sampled
// synchronously and ADDR_W >= 16; the run addresses are zero-extended.
module nv_seq_detector #(
    parameter int ADDR_W      = 16,
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              hsb_n,
    output logic              io_hiz,
    output logic              store_start,
    output logic              recall_start
);

    logic              busy;
    logic              acc_start;
    logic              acc_end_clean;
    logic              acc_end_dirty;
    logic              wr_hit;
    logic [ADDR_W-1:0] lat_addr;
    logic              fire_store;
    logic              fire_recall;

    nvss_access_tracker #(.ADDR_W(ADDR_W)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold          (busy),
        .addr          (addr),
        .ce_n          (ce_n),
        .oe_n          (oe_n),
        .we_n          (we_n),
        .acc_start     (acc_start),
        .acc_end_clean (acc_end_clean),
        .acc_end_dirty (acc_end_dirty),
        .wr_hit        (wr_hit),
        .lat_addr      (lat_addr)
    );

    nvss_seq_matcher #(.ADDR_W(ADDR_W)) u_match (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_start     (acc_start),
        .start_addr    (addr),
        .acc_end_clean (acc_end_clean),
        .acc_end_dirty (acc_end_dirty),
        .wr_hit        (wr_hit),
        .lat_addr      (lat_addr),
        .fire_store    (fire_store),
        .fire_recall   (fire_recall)
    );

    nvss_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_store     (fire_store),
        .go_recall    (fire_recall),
        .busy         (busy),
        .store_start  (store_start),
        .recall_start (recall_start)
    );

    // Pin levels follow the busy window.
    always_comb begin
        hsb_n  = ~busy;
        io_hiz = busy;
    end

    // R2 / R3: store and recall never start together.
    a_r3_single_operation: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_start && recall_start));

    // R10: outside busy the data pins are driven.
    a_r10_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        hsb_n |-> !io_hiz);

endmodule

// File: tb/nv_seq_detector_tb.sv
// Bench: drives bus patterns and compares all outputs, every clock, against a
// behavioural model that keeps a queue of the clean reads seen so far.
module nv_seq_detector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int BUSY       = 20;
    localparam int WATCHDOG   = 50000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic              hsb_n, io_hiz, store_start, recall_start;

    nv_seq_detector #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .hsb_n(hsb_n), .io_hiz(io_hiz),
        .store_start(store_start), .recall_start(recall_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Run addresses, written from the requirements.
    logic [15:0] run_pfx [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
    localparam logic [15:0] ST6 = 16'h8FC0;
    localparam logic [15:0] RC6 = 16'h4C63;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Reference model state.
    logic [15:0] hist [$];
    bit          m_prev_rd, m_in_acc, m_taint, m_busy;
    logic [15:0] m_lat;
    int          m_left;
    bit          e_hsb_n = 1, e_hiz = 0, e_st = 0, e_rc = 0;

    function automatic bit hist_is_prefix();
        for (int i = 0; i < hist.size(); i++)
            if (i >= 5 || hist[i] != run_pfx[i]) return 0;
        return 1;
    endfunction

    // Cycle model updated on each rising edge from the inputs it sees.
    always @(posedge clk) begin
        bit rd;
        rd = !ce_n && !oe_n && we_n;
        e_st = 0;
        e_rc = 0;
        if (!rst_n) begin
            hist.delete();
            m_prev_rd = 0; m_in_acc = 0; m_taint = 0; m_busy = 0; m_left = 0;
        end else if (m_busy) begin
            m_in_acc = 0;
            m_left--;
            if (m_left == 0) m_busy = 0;
        end else if (!ce_n && !we_n) begin
            hist.delete();
            m_in_acc = 0;
        end else if (rd && !m_prev_rd) begin
            if (hist.size() == 5 && (addr == ST6 || addr == RC6)) begin
                e_st = (addr == ST6);
                e_rc = (addr == RC6);
                m_busy = 1;
                m_left = BUSY;
                hist.delete();
            end else begin
                m_in_acc = 1; m_lat = addr; m_taint = 0;
            end
        end else if (m_in_acc && rd) begin
            if (addr != m_lat) m_taint = 1;
        end else if (m_in_acc && !rd) begin
            m_in_acc = 0;
            if (m_taint) hist.delete();
            else begin
                hist.push_back(m_lat);
                while (hist.size() > 0 && !hist_is_prefix()) void'(hist.pop_front());
            end
        end
        m_prev_rd = rd;
        e_hsb_n = !m_busy;
        e_hiz   = m_busy;
    end

    task automatic cmp1(string nm, string rq, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", rq, nm, act, exp, $time);
        end
    endtask

    // Compare away from the active edge.
    always @(negedge clk) begin
        cmp1("store_start",  cur_req, store_start,  e_st);
        cmp1("recall_start", cur_req, recall_start, e_rc);
        cmp1("hsb_n",        cur_req, hsb_n,        e_hsb_n);
        cmp1("io_hiz",       cur_req, io_hiz,       e_hiz);
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    // OE-controlled read: address, CE low, OE low, OE high, CE high.
    task automatic rd_oe(logic [15:0] a);
        addr = a; tick();
        ce_n = 0; tick();
        oe_n = 0; tick(2);
        oe_n = 1; tick();
        ce_n = 1; tick();
    endtask

    // CE-controlled read: address, OE low, CE low, CE high, OE high.
    task automatic rd_ce(logic [15:0] a);
        addr = a; tick();
        oe_n = 0; tick();
        ce_n = 0; tick(2);
        ce_n = 1; tick();
        oe_n = 1; tick();
    endtask

    // Address-controlled read: strobes low first, address set afterwards.
    task automatic rd_addr_ctl(logic [15:0] a);
        addr = 16'h0001; tick();
        oe_n = 0; ce_n = 0; tick();
        addr = a; tick(2);
        ce_n = 1; oe_n = 1; tick();
    endtask

    task automatic wr(logic [15:0] a);
        addr = a; tick();
        ce_n = 0; we_n = 0; tick();
        we_n = 1; ce_n = 1; tick();
    endtask

    task automatic prefix_oe();
        for (int i = 0; i < 5; i++) rd_oe(run_pfx[i]);
    endtask

    initial begin
        tick(3);
        cur_req = "R1";                 // R1: reset state
        cmp1("hsb_n_reset", "R1", hsb_n, 1'b1);
        cmp1("io_hiz_reset", "R1", io_hiz, 1'b0);
        rst_n = 1; tick(2);

        cur_req = "R2";                 // R2 + R4: store run with OE-controlled reads
        prefix_oe(); rd_oe(ST6); tick(BUSY + 2);

        cur_req = "R3";                 // R3 + R4: recall run with CE-controlled reads
        for (int i = 0; i < 5; i++) rd_ce(run_pfx[i]);
        rd_ce(RC6); tick(BUSY + 2);

        cur_req = "R4";                 // R4: mixed strobe orders still complete
        rd_ce(run_pfx[0]); rd_oe(run_pfx[1]); rd_ce(run_pfx[2]);
        rd_oe(run_pfx[3]); rd_ce(run_pfx[4]); rd_oe(ST6); tick(BUSY + 2);

        cur_req = "R5";                 // R5: address-controlled read cancels
        rd_oe(run_pfx[0]); rd_oe(run_pfx[1]); rd_addr_ctl(run_pfx[2]);
        rd_oe(run_pfx[3]); rd_oe(run_pfx[4]); rd_oe(ST6); tick(4);

        cur_req = "R6";                 // R6: wrong address cancels
        rd_oe(run_pfx[0]); rd_oe(run_pfx[1]); rd_oe(16'h1234);
        rd_oe(run_pfx[2]); rd_oe(run_pfx[3]); rd_oe(run_pfx[4]); rd_oe(ST6); tick(4);
        // R6: stray first address restarts at step one
        rd_oe(run_pfx[0]); rd_oe(run_pfx[1]); rd_oe(run_pfx[0]);
        for (int i = 1; i < 5; i++) rd_oe(run_pfx[i]);
        rd_oe(RC6); tick(BUSY + 2);

        cur_req = "R7";                 // R7: write in the middle cancels
        rd_oe(run_pfx[0]); rd_oe(run_pfx[1]); rd_oe(run_pfx[2]); wr(run_pfx[3]);
        rd_oe(run_pfx[3]); rd_oe(run_pfx[4]); rd_oe(ST6); tick(4);

        cur_req = "R8";                 // R8: busy width with a long sixth read
        prefix_oe();
        addr = ST6; tick(); ce_n = 0; tick(); oe_n = 0; tick(BUSY + 6);
        cur_req = "R9";                 // R9: read held across busy end does not count
        oe_n = 1; tick(); ce_n = 1; tick(2);
        // R9: reads during busy are ignored
        prefix_oe(); rd_oe(ST6);
        rd_oe(run_pfx[0]); rd_oe(run_pfx[1]); rd_oe(run_pfx[2]); wr(16'h0000);
        tick(BUSY);
        rd_oe(run_pfx[3]); rd_oe(run_pfx[4]); rd_oe(RC6); tick(4);

        cur_req = "R10";                // R10: ordinary traffic and a mismatching sixth read
        rd_oe(16'h0000); rd_ce(16'hFFFF); wr(16'h4E38); rd_oe(16'h4E38);
        prefix_oe(); rd_oe(16'h8FC1); tick(4);

        finish_run();
    end

endmodule